// File: doc/BRIEF.md
# Synchronous Byte-Lane Write SRAM

This block is a clocked single-port memory holding words of four 9-bit lanes (36 bits). Every command is taken on the rising clock edge from an active-low select, an active-low write strobe and four active-low lane enables. A read returns the whole word in the cycle after the edge that took the command. A write takes its data in the same cycle as its command and changes only the lanes whose enable is low.

A sleep input overrides every other input. While it is high, nothing is read or written. The read path is shown as a registered 36-bit data bus plus a drive-enable flag. When the flag is low the bus reads as zero, which models an undriven output without using tristate pads. The storage depth comes from the address width parameter.

Top module: `sbw_sram`

## Requirements
- R1: During and after synchronous reset, `rd_drive` is 0 and `rd_data` is all zeros until a read command is taken.
- R2: A command taken with `sleep`=0, `cs_n`=0 and `we_n`=1 is a read. In the next cycle `rd_drive` is 1 and `rd_data` holds the full 36-bit word stored at `addr`.
- R3: A command with `sleep`=0, `cs_n`=0 and `we_n`=0 writes `wdata` lane i into memory for each `lane_n[i]` that is 0. Lane 0 is bits 8:0, lane 1 is bits 17:9, lane 2 is bits 26:18 and lane 3 is bits 35:27. Lanes whose enable is 1 keep their old contents.
- R4: In the cycle after a write command, `rd_drive` is 0.
- R5: A write command with `lane_n`=4'b1111 is aborted. It changes no stored word, and `rd_drive` is 0 in the next cycle.
- R6: With `cs_n`=1 (and `sleep`=0), the cycle is a deselect whatever `we_n` says. No word changes, and `rd_drive` is 0 in the next cycle.
- R7: With `sleep`=1, all other inputs are ignored. No word changes, and `rd_drive` is 0 in the next cycle.
- R8: Whenever `rd_drive` is 0, `rd_data` is all zeros.
- R9: A read of the address written in the cycle before returns the newly written lanes merged with the unchanged old lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep | input | 1 | Overrides all commands when high |
| cs_n | input | 1 | Active-low select |
| we_n | input | 1 | Active-low write strobe |
| lane_n | input | 4 | Active-low per-lane write enables |
| addr | input | ADDR_W | Word address, taken with the command |
| wdata | input | 36 | Write data, taken with a write command |
| rd_data | output | 36 | Registered read word, zero when not driven |
| rd_drive | output | 1 | High in the cycle after a read command |

## Verification
The bench builds the block with `ADDR_W`=4, which gives 16 words. With so few words, random traffic often hits an address it has just written, reads it in the very next cycle, and overwrites words lane by lane on top of older partial writes. That brings the write-then-read and lane-merge cases within easy reach. The default 10-bit width is left for the lint build. Directed steps cover every single-lane write, aborted writes, a deselect that carries a write strobe, and sleep combined with an active write.

// File: rtl/sbw_pkg.sv
package sbw_pkg;
  localparam int LANE_W = 9;
  localparam int LANES  = 4;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_ABORT = 2'd3
  } op_e;
endpackage

// File: rtl/sbw_decode.sv
module sbw_decode
  import sbw_pkg::*;
#(
  parameter int N_LANES = LANES
) (
  input  logic               sleep,
  input  logic               cs_n,
  input  logic               we_n,
  input  logic [N_LANES-1:0] lane_n,
  output op_e                op,
  output logic               rd_en,
  output logic [N_LANES-1:0] lane_we
);
  always_comb begin
    if (sleep || cs_n)      op = OP_IDLE;
    else if (we_n)          op = OP_READ;
    else if (&lane_n)       op = OP_ABORT;
    else                    op = OP_WRITE;
  end

  assign rd_en = (op == OP_READ);

  for (genvar i = 0; i < N_LANES; i++) begin : g_we
    assign lane_we[i] = (op == OP_WRITE) && !lane_n[i];
  end
endmodule

// File: rtl/sbw_lane_bank.sv
module sbw_lane_bank #(
  parameter int ADDR_W = 10,
  parameter int W      = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  // Registered read port; output register clears when not reading.
  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[addr];
    else         rdata <= '0;
  end
endmodule

// File: rtl/sbw_out_stage.sv
module sbw_out_stage (
  input  logic clk,
  input  logic rst,
  input  logic rd_en,
  output logic drive
);
  always_ff @(posedge clk) begin
    if (rst) drive <= 1'b0;
    else     drive <= rd_en;
  end
endmodule

// File: rtl/sbw_sram.sv
module sbw_sram
  import sbw_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic [LANES-1:0]  lane_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_drive
);
  op_e              op;
  logic             rd_en;
  logic [LANES-1:0] lane_we;

  sbw_decode #(.N_LANES(LANES)) u_dec (
    .sleep   (sleep),
    .cs_n    (cs_n),
    .we_n    (we_n),
    .lane_n  (lane_n),
    .op      (op),
    .rd_en   (rd_en),
    .lane_we (lane_we)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    sbw_lane_bank #(.ADDR_W(ADDR_W), .W(LANE_W)) u_bank (
      .clk   (clk),
      .rst   (rst),
      .we    (lane_we[i]),
      .re    (rd_en),
      .addr  (addr),
      .wdata (wdata[i*LANE_W +: LANE_W]),
      .rdata (rd_data[i*LANE_W +: LANE_W])
    );
  end

  sbw_out_stage u_out (
    .clk   (clk),
    .rst   (rst),
    .rd_en (rd_en),
    .drive (rd_drive)
  );
endmodule

// File: rtl/sbw_sram_chk.sv
module sbw_sram_chk #(
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rst,
  input logic              sleep,
  input logic              cs_n,
  input logic              we_n,
  input logic [3:0]        lane_n,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_drive
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!rd_drive && rd_data == '0));

  assert_read_drives_R2: assert property (@(posedge clk) disable iff (rst)
    (!sleep && !cs_n && we_n) |=> rd_drive);

  assert_write_undriven_R4: assert property (@(posedge clk) disable iff (rst)
    (!sleep && !cs_n && !we_n) |=> !rd_drive);

  assert_abort_undriven_R5: assert property (@(posedge clk) disable iff (rst)
    (!sleep && !cs_n && !we_n && lane_n == 4'hF) |=> !rd_drive);

  assert_deselect_undriven_R6: assert property (@(posedge clk) disable iff (rst)
    (!sleep && cs_n) |=> !rd_drive);

  assert_sleep_undriven_R7: assert property (@(posedge clk) disable iff (rst)
    sleep |=> !rd_drive);

  assert_zero_when_off_R8: assert property (@(posedge clk) disable iff (rst)
    !rd_drive |-> rd_data == '0);
endmodule

bind sbw_sram sbw_sram_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .sleep    (sleep),
  .cs_n     (cs_n),
  .we_n     (we_n),
  .lane_n   (lane_n),
  .rd_data  (rd_data),
  .rd_drive (rd_drive)
);

// File: tb/sbw_sram_bench.sv
module sbw_sram_bench;
  localparam int AW    = 4;
  localparam int DW    = 36;
  localparam int WORDS = 1 << AW;

  logic          clk = 1'b0;
  logic          rst;
  logic          sleep, cs_n, we_n;
  logic [3:0]    lane_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rd_data;
  logic          rd_drive;

  logic [DW-1:0] ref_mem [WORDS];
  int n_chk = 0;
  int n_fail = 0;
  logic          last_wr;
  logic [AW-1:0] last_addr;

  always #4 clk = ~clk;

  sbw_sram #(.ADDR_W(AW)) u_sbw_sram (
    .clk(clk), .rst(rst), .sleep(sleep), .cs_n(cs_n), .we_n(we_n),
    .lane_n(lane_n), .addr(addr), .wdata(wdata),
    .rd_data(rd_data), .rd_drive(rd_drive)
  );

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w,
                                          input logic [DW-1:0] new_w,
                                          input logic [3:0] en_n);
    logic [DW-1:0] r = old_w;
    for (int i = 0; i < 4; i++)
      if (!en_n[i]) r[i*9 +: 9] = new_w[i*9 +: 9];
    return r;
  endfunction

  // One command: drive at negedge, model at posedge, check at next negedge.
  task automatic step(input logic s, input logic c, input logic w,
                      input logic [3:0] ln, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input string req);
    logic          ev;
    logic [DW-1:0] ed;
    string         tag;
    sleep = s; cs_n = c; we_n = w; lane_n = ln; addr = a; wdata = d;
    @(posedge clk);
    ev = !s && !c && w;
    ed = ev ? ref_mem[a] : '0;
    tag = (ev && last_wr && last_addr == a) ? {req, "/R9"} : req;
    if (!s && !c && !w) ref_mem[a] = merge(ref_mem[a], d, ln);
    last_wr = !s && !c && !w && (ln != 4'hF);
    last_addr = a;
    @(negedge clk);
    check(rd_drive === ev, tag, {35'd0, rd_drive}, {35'd0, ev});
    check(rd_data === ed, ev ? tag : {tag, "/R8"}, rd_data, ed);
  endtask

  function automatic logic [DW-1:0] rnd36();
    return {$urandom, $urandom};
  endfunction

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    last_wr = 1'b0; last_addr = '0;
    rst = 1'b1; sleep = 1'b0; cs_n = 1'b1; we_n = 1'b1; lane_n = 4'hF;
    addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    check(rd_drive === 1'b0, "R1", {35'd0, rd_drive}, '0);
    check(rd_data === '0, "R1", rd_data, '0);
    rst = 1'b0;

    // Fill every word with all lanes, then read back.
    for (int a = 0; a < WORDS; a++) step(0, 0, 0, 4'h0, AW'(a), rnd36(), "R3");
    for (int a = 0; a < WORDS; a++) step(0, 0, 1, 4'hF, AW'(a), '0, "R2");

    // Each single lane, each read back right after the write.
    for (int i = 0; i < 4; i++) begin
      step(0, 0, 0, ~(4'b1 << i), 4'd5, {4{9'(9'h1A0 + i)}}, "R3");
      step(0, 0, 1, 4'hF, 4'd5, '0, "R3");
    end

    // Aborted write, deselect with write strobe, sleep over a write.
    step(0, 0, 0, 4'hF, 4'd5, '1, "R5");
    step(0, 0, 1, 4'hF, 4'd5, '0, "R5");
    step(0, 1, 0, 4'h0, 4'd5, '1, "R6");
    step(0, 1, 1, 4'h0, 4'd5, '1, "R6");
    step(0, 0, 1, 4'hF, 4'd5, '0, "R6");
    step(1, 0, 0, 4'h0, 4'd5, '1, "R7");
    step(1, 0, 1, 4'hF, 4'd5, '0, "R7");
    step(0, 0, 1, 4'hF, 4'd5, '0, "R7");

    // Write then read next cycle at a fresh address.
    step(0, 0, 0, 4'b1010, 4'd9, 36'h123456789, "R4");
    step(0, 0, 1, 4'hF, 4'd9, '0, "R9");

    // Reset mid-run clears the read path.
    step(0, 0, 1, 4'hF, 4'd2, '0, "R2");
    rst = 1'b1;
    @(negedge clk);
    check(rd_drive === 1'b0, "R1", {35'd0, rd_drive}, '0);
    check(rd_data === '0, "R1", rd_data, '0);
    rst = 1'b0; last_wr = 1'b0;

    // Constrained random traffic.
    for (int n = 0; n < 3000; n++) begin
      int k = $urandom_range(0, 15);
      logic s = (k == 0);
      logic c = (k == 1);
      logic w = (k < 8);
      logic [3:0] ln = ($urandom_range(0, 5) == 0) ? 4'hF : 4'($urandom);
      step(s, c, w, ln, AW'($urandom), rnd36(), s ? "R7" : c ? "R6" : w ? "R2" : "R3");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule